// File: doc/BRIEF.md
# External Data Space Address Router

This block sits between an 8051-style core and the targets of its external-data moves. Each cycle the core may present one access. A wide access carries a full 16-bit pointer. A narrow access carries only an 8-bit index, and the block supplies the upper byte from a page register that it holds. The block forms the effective address and raises exactly one of three target selects: the internal XRAM, the CAN controller register window, or the external memory bus. It passes the core's write data out to the targets and returns the selected target's read data to the core.

The page register is loaded and read through a special-function-register port at SFR address 91h. For narrow accesses it does for the internal windows what Port 2 does for external memory. When the composed page:index address falls outside both internal windows, the access goes to the external bus, and the upper address byte comes from a Port 2 value input instead. The decoding is combinational, and only the page register holds state.

Top module: `xdata_router`

## Requirements
- R1: A wide access (acc_wide=1) whose pointer lies in F800h..FFFFh raises tgt_sel=3'b001 (XRAM) and drives eff_addr equal to the pointer.
- R2: A wide access whose pointer lies in F700h..F7FFh raises tgt_sel=3'b010 (CAN window) and drives eff_addr equal to the pointer.
- R3: A wide access whose pointer lies below F700h raises tgt_sel=3'b100 (external bus) and drives eff_addr equal to the pointer.
- R4: A narrow access (acc_wide=0) composes {page, acc_idx}. If that address lies in either internal window, the matching select from R1/R2 is raised and eff_addr equals the composed address.
- R5: A narrow access whose composed address lies in neither window raises tgt_sel=3'b100 and drives eff_addr = {p2_val, acc_idx}.
- R6: The page register resets to 00h. An SFR write (sfr_wr=1) at sfr_addr=91h loads sfr_wdata at the next rising clock edge. An SFR read at 91h returns the current value on sfr_rdata, with sfr_hit=1.
- R7: An SFR write to any address other than 91h leaves the page register unchanged.
- R8: While acc_valid=1 exactly one bit of tgt_sel is set. While acc_valid=0, tgt_sel is 000 and tgt_we and tgt_re are 0. Otherwise tgt_we=acc_write and tgt_re=!acc_write.
- R9: acc_rdata equals the read data of the selected target (xram_rdata, can_rdata or ext_rdata), and tgt_wdata equals acc_wdata.
- R10: At any SFR address other than 91h, sfr_hit is 0 and sfr_rdata is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_wide | input | 1 | 1: 16-bit pointer access, 0: 8-bit indexed access |
| acc_write | input | 1 | 1: write, 0: read |
| acc_ptr | input | 16 | Pointer for wide accesses |
| acc_idx | input | 8 | Index byte for narrow accesses |
| acc_wdata | input | 8 | Write data from the core |
| acc_rdata | output | 8 | Read data to the core |
| p2_val | input | 8 | Port 2 value, high byte for external narrow accesses |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (page register on a hit) |
| sfr_hit | output | 1 | SFR address selects the page register |
| eff_addr | output | 16 | Effective address to the targets |
| tgt_sel | output | 3 | One-hot select: bit0 XRAM, bit1 CAN, bit2 external |
| tgt_we | output | 1 | Target write strobe |
| tgt_re | output | 1 | Target read strobe |
| tgt_wdata | output | 8 | Write data to the targets |
| xram_rdata | input | 8 | XRAM read data |
| can_rdata | input | 8 | CAN window read data |
| ext_rdata | input | 8 | External bus read data |

## Verification
The only state in the block is the page register. A wrong page value shows up in the same cycle as a narrow access, either as a wrong high byte on eff_addr or as the wrong target select, and an SFR read at 91h exposes it directly. A page value corrupted by an SFR write to another address is visible one edge after that write. Decode errors need no state to appear: a misplaced window edge changes tgt_sel combinationally, so the bench sweeps every pointer high byte and every page value with distinct read data on each target.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
   localparam int NTGT = 3;
   typedef enum int {TGT_XRAM = 0, TGT_CAN = 1, TGT_EXT = 2} tgt_e;

   function automatic logic in_window(input logic [15:0] probe,
                                      input logic [15:0] base,
                                      input int unsigned span);
      logic [16:0] diff;
      diff = {1'b0, probe} - {1'b0, base};
      return !diff[16] && (diff < 17'(span));
   endfunction
endpackage

// File: rtl/xdr_page_reg.sv
module xdr_page_reg #(
   parameter int          DW        = 8,
   parameter int          SFR_AW    = 8,
   parameter logic [7:0]  PAGE_ADDR = 8'h91
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [DW-1:0]     sfr_wdata,
   output logic [DW-1:0]     page_q,
   output logic [DW-1:0]     sfr_rdata,
   output logic              sfr_hit
);
   localparam logic [SFR_AW-1:0] HIT_ADDR = SFR_AW'(PAGE_ADDR);

   assign sfr_hit   = (sfr_addr == HIT_ADDR);
   assign sfr_rdata = sfr_hit ? page_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 page_q <= '0;
      else if (sfr_wr && sfr_hit) page_q <= sfr_wdata;
   end
endmodule

// File: rtl/xdr_decode.sv
module xdr_decode
   import xdr_pkg::*;
#(
   parameter int          AW        = 16,
   parameter int          DW        = 8,
   parameter logic [15:0] XRAM_BASE = 16'hF800,
   parameter int unsigned XRAM_SPAN = 2048,
   parameter logic [15:0] CAN_BASE  = 16'hF700,
   parameter int unsigned CAN_SPAN  = 256
) (
   input  logic            acc_valid,
   input  logic            acc_wide,
   input  logic [AW-1:0]   acc_ptr,
   input  logic [DW-1:0]   acc_idx,
   input  logic [DW-1:0]   page,
   input  logic [DW-1:0]   p2_val,
   output logic [AW-1:0]   eff_addr,
   output logic [NTGT-1:0] tgt_oh
);
   logic [AW-1:0]   composed;
   logic [AW-1:0]   probe;
   logic [NTGT-1:0] hit;

   assign composed = {page, acc_idx};
   assign probe    = acc_wide ? acc_ptr : composed;

   localparam logic [15:0]  BASES [2] = '{XRAM_BASE, CAN_BASE};
   localparam int unsigned  SPANS [2] = '{XRAM_SPAN, CAN_SPAN};

   for (genvar w = 0; w < 2; w++) begin : g_win
      assign hit[w] = in_window(16'(probe), BASES[w], SPANS[w]);
   end
   assign hit[TGT_EXT] = !(hit[TGT_XRAM] || hit[TGT_CAN]);

   always_comb begin
      tgt_oh = '0;
      if (acc_valid) begin
         if (hit[TGT_XRAM])     tgt_oh[TGT_XRAM] = 1'b1;
         else if (hit[TGT_CAN]) tgt_oh[TGT_CAN]  = 1'b1;
         else                   tgt_oh[TGT_EXT]  = 1'b1;
      end
   end

   always_comb begin
      if (acc_wide)            eff_addr = acc_ptr;
      else if (hit[TGT_EXT])   eff_addr = {p2_val, acc_idx};
      else                     eff_addr = composed;
   end
endmodule

// File: rtl/xdr_rdmux.sv
module xdr_rdmux #(
   parameter int DW        = 8,
   parameter int N         = 3,
   parameter bit AND_OR    = 1'b1
) (
   input  logic [N-1:0]    sel,
   input  logic [N*DW-1:0] rdata_flat,
   output logic [DW-1:0]   rdata
);
   if (AND_OR) begin : g_andor
      always_comb begin
         rdata = '0;
         for (int i = 0; i < N; i++)
            rdata = rdata | (rdata_flat[i*DW +: DW] & {DW{sel[i]}});
      end
   end else begin : g_prio
      always_comb begin
         rdata = '0;
         for (int i = N-1; i >= 0; i--)
            if (sel[i]) rdata = rdata_flat[i*DW +: DW];
      end
   end
endmodule

// File: rtl/xdata_router.sv
module xdata_router
   import xdr_pkg::*;
#(
   parameter int          AW        = 16,
   parameter int          DW        = 8,
   parameter int          SFR_AW    = 8,
   parameter logic [7:0]  PAGE_ADDR = 8'h91,
   parameter logic [15:0] XRAM_BASE = 16'hF800,
   parameter int unsigned XRAM_SPAN = 2048,
   parameter logic [15:0] CAN_BASE  = 16'hF700,
   parameter int unsigned CAN_SPAN  = 256,
   parameter bit          AND_OR    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_wide,
   input  logic              acc_write,
   input  logic [AW-1:0]     acc_ptr,
   input  logic [DW-1:0]     acc_idx,
   input  logic [DW-1:0]     acc_wdata,
   output logic [DW-1:0]     acc_rdata,
   input  logic [DW-1:0]     p2_val,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [DW-1:0]     sfr_wdata,
   output logic [DW-1:0]     sfr_rdata,
   output logic              sfr_hit,
   output logic [AW-1:0]     eff_addr,
   output logic [2:0]        tgt_sel,
   output logic              tgt_we,
   output logic              tgt_re,
   output logic [DW-1:0]     tgt_wdata,
   input  logic [DW-1:0]     xram_rdata,
   input  logic [DW-1:0]     can_rdata,
   input  logic [DW-1:0]     ext_rdata
);
   if (AW != 2*DW)                      begin : g_bad_aw   $error("AW must be twice DW"); end
   if (AW != 16)                        begin : g_bad_w    $error("window decode assumes AW of 16"); end
   if (32'(CAN_BASE) + CAN_SPAN > 32'(XRAM_BASE) && 32'(XRAM_BASE) + XRAM_SPAN > 32'(CAN_BASE))
                                        begin : g_overlap  $error("internal windows overlap"); end
   if (32'(XRAM_BASE) + XRAM_SPAN > 65536) begin : g_xr_big $error("XRAM window exceeds space"); end
   if (32'(CAN_BASE) + CAN_SPAN > 65536)   begin : g_cn_big $error("CAN window exceeds space"); end

   logic [DW-1:0]   page_q;
   logic [NTGT-1:0] tgt_oh;

   xdr_page_reg #(.DW(DW), .SFR_AW(SFR_AW), .PAGE_ADDR(PAGE_ADDR)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .sfr_addr  (sfr_addr),
      .sfr_wr    (sfr_wr),
      .sfr_wdata (sfr_wdata),
      .page_q    (page_q),
      .sfr_rdata (sfr_rdata),
      .sfr_hit   (sfr_hit)
   );

   xdr_decode #(.AW(AW), .DW(DW), .XRAM_BASE(XRAM_BASE), .XRAM_SPAN(XRAM_SPAN),
                .CAN_BASE(CAN_BASE), .CAN_SPAN(CAN_SPAN)) u_dec (
      .acc_valid (acc_valid),
      .acc_wide  (acc_wide),
      .acc_ptr   (acc_ptr),
      .acc_idx   (acc_idx),
      .page      (page_q),
      .p2_val    (p2_val),
      .eff_addr  (eff_addr),
      .tgt_oh    (tgt_oh)
   );

   xdr_rdmux #(.DW(DW), .N(NTGT), .AND_OR(AND_OR)) u_rmux (
      .sel        (tgt_oh),
      .rdata_flat ({ext_rdata, can_rdata, xram_rdata}),
      .rdata      (acc_rdata)
   );

   assign tgt_sel   = tgt_oh;
   assign tgt_we    = acc_valid &  acc_write;
   assign tgt_re    = acc_valid & ~acc_write;
   assign tgt_wdata = acc_wdata;
endmodule

// File: rtl/xdr_checker.sv
module xdr_checker #(
   parameter int          AW        = 16,
   parameter int          DW        = 8,
   parameter int          SFR_AW    = 8,
   parameter logic [7:0]  PAGE_ADDR = 8'h91
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_wide,
   input logic [AW-1:0]     acc_ptr,
   input logic [DW-1:0]     p2_val,
   input logic [SFR_AW-1:0] sfr_addr,
   input logic              sfr_wr,
   input logic [DW-1:0]     sfr_wdata,
   input logic [DW-1:0]     page_q,
   input logic [AW-1:0]     eff_addr,
   input logic [2:0]        tgt_sel,
   input logic [DW-1:0]     acc_rdata,
   input logic [DW-1:0]     can_rdata
);
   localparam logic [SFR_AW-1:0] PA = SFR_AW'(PAGE_ADDR);

   p_xram_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wide && acc_ptr[AW-1:AW-5] == 5'b11111) |-> (tgt_sel == 3'b001 && eff_addr == acc_ptr));

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ($countones(tgt_sel) == 1));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (tgt_sel == 3'b000));

   p_ext_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_wide && tgt_sel[2]) |-> (eff_addr[AW-1:DW] == p2_val));

   p_page_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && sfr_addr == PA) |=> (page_q == $past(sfr_wdata)));

   p_page_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sfr_wr && sfr_addr == PA) |=> $stable(page_q));

   p_can_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && tgt_sel[1]) |-> (acc_rdata == can_rdata));
endmodule

bind xdata_router xdr_checker #(.AW(AW), .DW(DW), .SFR_AW(SFR_AW), .PAGE_ADDR(PAGE_ADDR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_wide  (acc_wide),
   .acc_ptr   (acc_ptr),
   .p2_val    (p2_val),
   .sfr_addr  (sfr_addr),
   .sfr_wr    (sfr_wr),
   .sfr_wdata (sfr_wdata),
   .page_q    (page_q),
   .eff_addr  (eff_addr),
   .tgt_sel   (tgt_sel),
   .acc_rdata (acc_rdata),
   .can_rdata (can_rdata)
);

// File: tb/tb_xdata_router.sv
module tb_xdata_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_wide = 1'b0, acc_write = 1'b0;
   logic [15:0] acc_ptr = '0;
   logic [7:0]  acc_idx = '0, acc_wdata = '0, p2_val = '0;
   logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  acc_rdata, sfr_rdata, tgt_wdata;
   logic        sfr_hit, tgt_we, tgt_re;
   logic [15:0] eff_addr;
   logic [2:0]  tgt_sel;
   logic [7:0]  xram_rdata = 8'hA1, can_rdata = 8'hC2, ext_rdata = 8'hE3;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   xdata_router dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wide(acc_wide),
      .acc_write(acc_write), .acc_ptr(acc_ptr), .acc_idx(acc_idx),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .p2_val(p2_val),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
      .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit), .eff_addr(eff_addr),
      .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_re(tgt_re), .tgt_wdata(tgt_wdata),
      .xram_rdata(xram_rdata), .can_rdata(can_rdata), .ext_rdata(ext_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_sel(input logic [15:0] a);
      if (a >= 16'hF800)      return 3'b001;
      else if (a >= 16'hF700) return 3'b010;
      else                    return 3'b100;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [2:0] s);
      case (s)
         3'b001:  return 8'hA1;
         3'b010:  return 8'hC2;
         default: return 8'hE3;
      endcase
   endfunction

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic page_check(input string req, input logic [7:0] exp);
      sfr_addr = 8'h91;
      #1;
      chk(req, {31'd0, sfr_hit}, 32'd1);
      chk(req, {24'd0, sfr_rdata}, {24'd0, exp});
   endtask

   initial begin : watchdog
      #1_500_000;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] lows [3];
      lows[0] = 8'h00; lows[1] = 8'h5A; lows[2] = 8'hFF;
      repeat (3) @(negedge clk);
      // R6: reset value of page register
      page_check("R6 reset", 8'h00);
      // R8: idle produces no select
      #1; chk("R8 idle", {29'd0, tgt_sel}, 32'd0);
      chk("R8 idle we", {31'd0, tgt_we | tgt_re}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R9: wide sweep over every high byte
      for (int h = 0; h < 256; h++) begin
         for (int l = 0; l < 3; l++) begin
            logic [15:0] a;
            logic [2:0]  es;
            a = {h[7:0], lows[l]};
            es = exp_sel(a);
            acc_valid = 1'b1; acc_wide = 1'b1; acc_ptr = a;
            acc_write = l[0]; acc_wdata = ~a[7:0];
            #1;
            if (es == 3'b001)      chk("R1 sel", {29'd0, tgt_sel}, {29'd0, es});
            else if (es == 3'b010) chk("R2 sel", {29'd0, tgt_sel}, {29'd0, es});
            else                   chk("R3 sel", {29'd0, tgt_sel}, {29'd0, es});
            chk("R3 eff", {16'd0, eff_addr}, {16'd0, a});
            chk("R9 rdata", {24'd0, acc_rdata}, {24'd0, exp_rd(es)});
            chk("R9 wdata", {24'd0, tgt_wdata}, {24'd0, ~a[7:0]});
            chk("R8 strobes", {30'd0, tgt_we, tgt_re}, {30'd0, l[0], ~l[0]});
            #4;
         end
      end
      acc_valid = 1'b0;

      // R4 R5 R6: every page value with several index bytes
      for (int p = 0; p < 256; p++) begin
         sfr_write(8'h91, p[7:0]);
         page_check("R6 load", p[7:0]);
         for (int l = 0; l < 3; l++) begin
            logic [15:0] c;
            logic [2:0]  es;
            c = {p[7:0], lows[l]};
            es = exp_sel(c);
            acc_valid = 1'b1; acc_wide = 1'b0; acc_write = 1'b0;
            acc_idx = lows[l]; p2_val = ~p[7:0] ^ lows[l];
            #1;
            if (es == 3'b100) begin
               chk("R5 sel", {29'd0, tgt_sel}, 32'd4);
               chk("R5 eff", {16'd0, eff_addr}, {16'd0, p2_val, lows[l]});
            end else begin
               chk("R4 sel", {29'd0, tgt_sel}, {29'd0, es});
               chk("R4 eff", {16'd0, eff_addr}, {16'd0, c});
            end
            chk("R9 rdata narrow", {24'd0, acc_rdata}, {24'd0, exp_rd(es)});
            #4;
         end
         acc_valid = 1'b0;
      end

      // R7 R10: writes elsewhere leave the page alone
      sfr_write(8'h91, 8'hF7);
      for (int k = 0; k < 256; k++) begin
         if (k != 8'h91) begin
            sfr_write(k[7:0], 8'h3C);
            #1;
            chk("R10 hit", {31'd0, sfr_hit}, 32'd0);
            chk("R10 rdata", {24'd0, sfr_rdata}, 32'd0);
            page_check("R7 hold", 8'hF7);
         end
      end
      // R4: page F7 with index routes to CAN
      acc_valid = 1'b1; acc_wide = 1'b0; acc_idx = 8'h10; p2_val = 8'h00;
      #1;
      chk("R4 can via page", {29'd0, tgt_sel}, 32'd2);
      chk("R4 can eff", {16'd0, eff_addr}, 32'h0000F710);
      acc_valid = 1'b0;
      #1;
      chk("R8 idle after", {29'd0, tgt_sel}, 32'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule